// File: doc/BRIEF.md
# Modulo-Eleven Clock Divider on a Loadable Binary Counter

This block divides an enabled clock stream by eleven. At its core is a 4-bit synchronous binary counter with a synchronous clear, a parallel load and two count enables. Every clear, load and increment takes effect on the rising clock edge. The counter also drives a combinational ripple-carry flag. A static wrap-mode input picks one of two ways to make the counter cycle through eleven states. In preset mode the counter runs to the top value and then reloads a preset. In clear mode the counter is forced back to zero after it reaches a terminal value.

The block provides three outputs: the count itself, a combinational terminal-count pulse, and a registered copy of that pulse. The registered copy is free of decode glitches and arrives one enabled edge after the combinational pulse. An active-high asynchronous reset is used only to initialise the block. The wrap mode must be changed only while the external clear is held.

Top module: `mod11_divider`

## Requirements
- R1: While `rst` is high, `count` is 0 and `term_q` is 0, with no clock edge needed.
- R2: Synchronous clear has the highest priority. When `clr` is 1 at a rising edge, `count` becomes 0 and `term_q` becomes 0, even if a wrap reload or an increment would otherwise happen.
- R3: With `clr` at 0 and no terminal state, `count` increments by 1 on each edge where `enp` and `ent` are both 1. If either enable is 0, both `count` and `term_q` hold their values.
- R4: `rco` is combinational. It is 1 exactly when `ent` is 1 and `count` is 15, regardless of `enp`, `mode` and `clr`.
- R5: With `mode`=0 (preset mode), an enabled edge at `count`=15 loads 5. The steady cycle is then 5, 6, …, 15, 5, which has 11 states.
- R6: With `mode`=1 (clear mode), an enabled edge at `count`=10 returns the count to 0. The cycle is 0, 1, …, 10, 0, which has 11 states.
- R7: `term` is combinational. It is 1 when `enp` and `ent` are both 1 and `count` equals the terminal value: 15 in preset mode, 10 in clear mode.
- R8: `term_q` takes the value `term` had at each enabled edge. It is therefore a one-cycle pulse that occurs exactly once every 11 enabled clocks.
- R9: After reset in preset mode, the first pass counts from 0 up to 15 before the 11-state cycle begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Asynchronous active-high reset |
| mode | input | 1 | Wrap mode: 0 reloads preset at the top, 1 clears after the terminal value |
| clr | input | 1 | Synchronous clear, highest priority |
| enp | input | 1 | Count enable, parallel |
| ent | input | 1 | Count enable, also gates the carry |
| count | output | 4 | Current count |
| rco | output | 1 | Ripple carry: `ent` and count at 15 |
| term | output | 1 | Combinational terminal-count pulse |
| term_q | output | 1 | Registered terminal pulse, free of glitches |

## Verification
The bench applies clear at count 15 in preset mode. A design that ranked load above clear would land on 5 there instead of 0. It drops each enable on its own, including on a terminal state. This exposes a design that still reloads, still counts, or changes the registered pulse while frozen. The bench also follows the first pass after reset in preset mode, which must climb from 0, and it measures the spacing of `term_q` pulses in both modes. A wrong terminal decode or an off-by-one wrap would show up as a period other than eleven.

// File: rtl/mod11_pkg.sv
package mod11_pkg;

   typedef enum logic {
      WRAP_PRESET = 1'b0,
      WRAP_CLEAR  = 1'b1
   } wrap_mode_e;

   // True when no value below term shares all of term's one-bits,
   // so a masked compare identifies term uniquely in 0..term.
   function automatic bit sparse_ok(input int term);
      for (int v = 0; v < term; v++) begin
         if ((v & term) == term) return 1'b0;
      end
      return 1'b1;
   endfunction

endpackage

// File: rtl/mod11_cnt_core.sv
module mod11_cnt_core #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         clr,
   input  logic         ld,
   input  logic         enp,
   input  logic         ent,
   input  logic [W-1:0] din,
   output logic [W-1:0] q,
   output logic         rco
);

   if (W < 2) begin : g_bad_width
      $error("mod11_cnt_core: W must be at least 2");
   end

   always_ff @(posedge clk or posedge rst) begin
      if (rst)             q <= '0;
      else if (clr)        q <= '0;
      else if (ld)         q <= din;
      else if (enp && ent) q <= q + 1'b1;
   end

   assign rco = ent & (&q);

   assert_clr_wins_R2: assert property (@(posedge clk) disable iff (rst)
      clr |=> (q == '0));
   assert_load_R5: assert property (@(posedge clk) disable iff (rst)
      (!clr && ld) |=> (q == $past(din)));
   assert_inc_R3: assert property (@(posedge clk) disable iff (rst)
      (!clr && !ld && enp && ent) |=> (q == $past(q) + 1'b1));
   assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
      (!clr && !ld && !(enp && ent)) |=> $stable(q));

endmodule

// File: rtl/mod11_term_detect.sv
module mod11_term_detect
   import mod11_pkg::*;
#(
   parameter int W        = 4,
   parameter int TERM_VAL = 10,
   parameter bit SPARSE   = 1'b1
) (
   input  logic [W-1:0] q,
   input  wrap_mode_e   mode,
   output logic         at_term
);

   localparam logic [W-1:0] TERM_V = W'(TERM_VAL);

   logic top_hit;
   logic clr_hit;

   assign top_hit = &q;

   if (SPARSE) begin : g_masked
      if (!sparse_ok(TERM_VAL)) begin : g_bad_mask
         $error("mod11_term_detect: masked decode is ambiguous for TERM_VAL");
      end
      assign clr_hit = ((q & TERM_V) == TERM_V);
   end else begin : g_full
      assign clr_hit = (q == TERM_V);
   end

   assign at_term = (mode == WRAP_CLEAR) ? clr_hit : top_hit;

endmodule

// File: rtl/mod11_pulse_reg.sv
module mod11_pulse_reg (
   input  logic clk,
   input  logic rst,
   input  logic clr,
   input  logic en,
   input  logic d,
   output logic q
);

   always_ff @(posedge clk or posedge rst) begin
      if (rst)     q <= 1'b0;
      else if (clr) q <= 1'b0;
      else if (en)  q <= d;
   end

   assert_delay_R8: assert property (@(posedge clk) disable iff (rst)
      (!clr && en) |=> (q == $past(d)));
   assert_freeze_R3: assert property (@(posedge clk) disable iff (rst)
      (!clr && !en) |=> $stable(q));
   assert_clr_R2: assert property (@(posedge clk) disable iff (rst)
      clr |=> !q);

endmodule

// File: rtl/mod11_divider.sv
module mod11_divider
   import mod11_pkg::*;
#(
   parameter int W          = 4,
   parameter int PRESET_VAL = 5,
   parameter int TERM_VAL   = 10,
   parameter bit SPARSE     = 1'b1
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         mode,
   input  logic         clr,
   input  logic         enp,
   input  logic         ent,
   output logic [W-1:0] count,
   output logic         rco,
   output logic         term,
   output logic         term_q
);

   localparam int TOP_VAL      = (1 << W) - 1;
   localparam int RATIO_PRESET = TOP_VAL - PRESET_VAL + 1;
   localparam int RATIO_CLEAR  = TERM_VAL + 1;
   localparam logic [W-1:0] PRESET_V = W'(PRESET_VAL);

   if (RATIO_PRESET != RATIO_CLEAR) begin : g_bad_ratio
      $error("mod11_divider: both wrap modes must give the same ratio");
   end
   if (TERM_VAL >= TOP_VAL || PRESET_VAL <= 0) begin : g_bad_range
      $error("mod11_divider: terminal or preset value out of range");
   end

   wrap_mode_e wmode;
   logic       en_both;
   logic       at_term;
   logic       core_clr;
   logic       core_ld;

   assign wmode   = wrap_mode_e'(mode);
   assign en_both = enp & ent;
   assign term    = at_term & en_both;

   // Clear mode wraps through the clear path, preset mode through the load path.
   assign core_clr = clr | (term & (wmode == WRAP_CLEAR));
   assign core_ld  = term & (wmode == WRAP_PRESET);

   mod11_term_detect #(
      .W        (W),
      .TERM_VAL (TERM_VAL),
      .SPARSE   (SPARSE)
   ) u_det (
      .q       (count),
      .mode    (wmode),
      .at_term (at_term)
   );

   mod11_cnt_core #(
      .W (W)
   ) u_core (
      .clk (clk),
      .rst (rst),
      .clr (core_clr),
      .ld  (core_ld),
      .enp (enp),
      .ent (ent),
      .din (PRESET_V),
      .q   (count),
      .rco (rco)
   );

   mod11_pulse_reg u_preg (
      .clk (clk),
      .rst (rst),
      .clr (clr),
      .en  (en_both),
      .d   (term),
      .q   (term_q)
   );

   assert_preset_wrap_R5: assert property (@(posedge clk) disable iff (rst)
      (!clr && !mode && en_both && count == W'(TOP_VAL)) |=> (count == PRESET_V));
   assert_clear_wrap_R6: assert property (@(posedge clk) disable iff (rst)
      (!clr && mode && en_both && count == W'(TERM_VAL)) |=> (count == '0));
   assert_reset_state_R1: assert property (@(posedge clk)
      rst |-> (count == '0 && !term_q));

endmodule

// File: tb/sim_mod11_divider.sv
module sim_mod11_divider;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       mode = 1'b0;
   logic       clr = 1'b0;
   logic       enp = 1'b0;
   logic       ent = 1'b0;
   logic [3:0] count;
   logic       rco, term, term_q;

   int checks = 0;
   int failures = 0;

   logic [3:0] m_cnt = 4'd0;
   logic       m_tq  = 1'b0;

   always #5 clk = ~clk;

   mod11_divider u0 (
      .clk(clk), .rst(rst), .mode(mode), .clr(clr), .enp(enp), .ent(ent),
      .count(count), .rco(rco), .term(term), .term_q(term_q)
   );

   // {mode, clr, enp, ent, repeats}
   localparam int NV = 12;
   localparam logic [11:0] VEC [NV] = '{
      {4'b0100, 8'd1},  {4'b0011, 8'd20}, {4'b0001, 8'd3},  {4'b0010, 8'd3},
      {4'b0011, 8'd15}, {4'b1100, 8'd1},  {4'b1011, 8'd25}, {4'b1001, 8'd3},
      {4'b1011, 8'd10}, {4'b1111, 8'd1},  {4'b1010, 8'd2},  {4'b1011, 8'd30}
   };

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic step(input logic md, input logic c, input logic p, input logic t);
      logic e_rco, e_term;
      @(negedge clk);
      mode = md; clr = c; enp = p; ent = t;
      #1;
      e_rco  = t && (m_cnt == 4'd15);
      e_term = p && t && (md ? (m_cnt == 4'd10) : (m_cnt == 4'd15));
      check("R4 rco", rco, e_rco);
      check("R7 term", term, e_term);
      if (c) begin
         m_cnt = 4'd0; m_tq = 1'b0;
      end else begin
         if (p && t) m_tq = e_term;
         if (e_term) m_cnt = md ? 4'd0 : 4'd5;
         else if (p && t) m_cnt = m_cnt + 4'd1;
      end
      @(posedge clk);
      #1;
      check("R2 R3 R5 R6 count", count, m_cnt);
      check("R8 term_q", term_q, m_tq);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1; clr = 1'b0; enp = 1'b0; ent = 1'b0;
      #1;
      check("R1 reset count", count, 0);
      check("R1 reset term_q", term_q, 0);
      @(negedge clk);
      rst = 1'b0;
      m_cnt = 4'd0; m_tq = 1'b0;
   endtask

   initial begin
      #2_000_000;
      failures++; checks++;
      $display("FAIL R1 watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      int pulses, last, gap_bad;
      do_reset();

      // table walk
      for (int i = 0; i < NV; i++) begin
         for (int r = 0; r < int'(VEC[i][7:0]); r++) begin
            step(VEC[i][11], VEC[i][10], VEC[i][9], VEC[i][8]);
         end
      end

      // R9: first pass after reset in preset mode climbs from 0 to 15
      do_reset();
      for (int i = 0; i < 15; i++) step(1'b0, 1'b0, 1'b1, 1'b1);
      check("R9 first pass top", count, 15);
      step(1'b0, 1'b0, 1'b1, 1'b1);
      check("R9 then preset", count, 5);

      // R4: carry follows ent only, at 15
      do_reset();
      for (int i = 0; i < 15; i++) step(1'b0, 1'b0, 1'b1, 1'b1);
      step(1'b0, 1'b0, 1'b0, 1'b1);
      check("R4 carry with enp low", rco, 1);
      check("R3 frozen at top", count, 15);
      step(1'b0, 1'b0, 1'b1, 1'b0);
      check("R3 frozen ent low", count, 15);

      // R2: clear beats reload at 15
      step(1'b0, 1'b1, 1'b1, 1'b1);
      check("R2 clear beats load", count, 0);

      // R8 and R6: pulse period in clear mode
      do_reset();
      step(1'b1, 1'b1, 1'b0, 1'b0);
      pulses = 0; last = -1; gap_bad = 0;
      for (int i = 0; i < 44; i++) begin
         step(1'b1, 1'b0, 1'b1, 1'b1);
         if (term_q) begin
            if (last >= 0 && (i - last) != 11) gap_bad++;
            last = i; pulses++;
         end
      end
      check("R6 R8 pulses in 44 clear-mode clocks", pulses, 4);
      check("R8 clear-mode pulse spacing", gap_bad, 0);

      // R8 and R5: pulse period in preset mode, after the first pass
      do_reset();
      for (int i = 0; i < 16; i++) step(1'b0, 1'b0, 1'b1, 1'b1);
      pulses = 0; last = -1; gap_bad = 0;
      for (int i = 0; i < 44; i++) begin
         step(1'b0, 1'b0, 1'b1, 1'b1);
         if (term_q) begin
            if (last >= 0 && (i - last) != 11) gap_bad++;
            last = i; pulses++;
         end
      end
      check("R5 R8 pulses in 44 preset-mode clocks", pulses, 4);
      check("R8 preset-mode pulse spacing", gap_bad, 0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule